// File: doc/BRIEF.md
# Scaled 48-bit Real-Time Counter

This block keeps wall-clock time in an always-on domain. A 48-bit counter advances once for every cycle in which the slow timebase tick input is high and counting is enabled. Software can load any time value by writing the count through two registers: a low word and a high halfword. A 4-bit scale setting selects a 32-bit window of the count, that is, the count shifted right by the scale. That window is compared against a 32-bit compare register. When the window reaches the compare value, the block raises an interrupt-pending flag and drives it on a dedicated output.

The block sits on a plain 32-bit register bus that has a write strobe and a combinational read port. That bus is control traffic and carries no data stream, so it has no valid/ready handshake. Each cycle performs at most one register write, and a read returns the register selected by the address in the same cycle. The timebase tick is a single-cycle enable that is synchronous to the block clock. Typically it pulses at 31250 Hz.

Top module: `rtc48_timer`

## Requirements
- R1: After reset the count is zero, the scale is 0, counting is disabled, the compare register holds 0xFFFFFFFF, and the pending flag and `irq_o` are low.
- R2: The registers are at these offsets: configuration 0x40, count low word 0x48, count high halfword 0x4C, compare 0x60. The compare register reads back what was written. A write to any other offset changes nothing, and a read from any other offset returns zero.
- R3: The count increases by exactly one on each clock edge where `tick_i` is high and the enable bit (configuration bit 12) is set. In all other cycles it holds.
- R4: A write to 0x48 loads count bits [31:0]. A write to 0x4C loads count bits [47:32] from write data bits [15:0]. Bits [31:16] of 0x4C always read as zero.
- R5: A write to either count register in a cycle that would also increment takes effect in place of the increment. The written value is read back unchanged.
- R6: When the count is 0xFFFF_FFFFFFFF, an increment wraps it to zero.
- R7: The compared window is bits [scale+31:scale] of the count, with zeros above bit 47. The scale is configuration bits [3:0].
- R8: The pending flag reads as configuration bit 28 and drives `irq_o`. It is high exactly while the window is greater than or equal to the compare value. It clears once the compare value is raised above the window.
- R9: Configuration bit 28 is read-only, and writing it has no effect. All configuration bits other than [3:0], 12 and 28 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick enable, one cycle per count step |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Compare-pending interrupt |

## Verification
The properties assume that `bus_wr` is low while reset is asserted. They also assume that inputs change only away from the rising edge, so each write strobe and each tick is seen in exactly one cycle. The bench meets both assumptions: it holds the bus idle through reset, and it drives every input on the falling clock edge. Its random register writes are limited to the four mapped offsets and one unmapped offset. Its compare values are drawn small often enough to make the pending flag toggle. Loads of a near-maximum high halfword push the count through wraparound.

// File: rtl/rtc48_pkg.sv
`timescale 1ns/1ps
package rtc48_pkg;
  // Register byte offsets decoded by the bus.
  localparam int OFF_CFG = 'h40;
  localparam int OFF_LO  = 'h48;
  localparam int OFF_HI  = 'h4C;
  localparam int OFF_CMP = 'h60;
  // Configuration field positions.
  localparam int CFG_EN_BIT   = 12;
  localparam int CFG_PEND_BIT = 28;
endpackage

// File: rtl/rtc48_counter.sv
`timescale 1ns/1ps
module rtc48_counter #(
  parameter int CNT_W  = 48,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // A load replaces the increment in the same cycle.
  always_comb begin
    cnt_d = cnt_q;
    if (ld_lo) begin
      cnt_d[DATA_W-1:0] = wdata;
    end else if (ld_hi) begin
      cnt_d[CNT_W-1:DATA_W] = wdata[HI_W-1:0];
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rtc48_scaler.sv
`timescale 1ns/1ps
module rtc48_scaler #(
  parameter int CNT_W   = 48,
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 4
) (
  input  logic [CNT_W-1:0]   cnt,
  input  logic [SCALE_W-1:0] scale,
  output logic [DATA_W-1:0]  window
);
  localparam int N_WIN = 1 << SCALE_W;

  logic [DATA_W-1:0] win [N_WIN];

  for (genvar s = 0; s < N_WIN; s++) begin : g_win
    logic [CNT_W-1:0] shifted;
    assign shifted = cnt >> s;
    assign win[s]  = shifted[DATA_W-1:0];
  end

  assign window = win[scale];
endmodule

// File: rtl/rtc48_cmp.sv
`timescale 1ns/1ps
module rtc48_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] window,
  input  logic [DATA_W-1:0] cmp,
  output logic              pend
);
  assign pend = (window >= cmp);
endmodule

// File: rtl/rtc48_regs.sv
`timescale 1ns/1ps
module rtc48_regs
  import rtc48_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 4,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               pend,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               ld_lo,
  output logic               ld_hi,
  output logic [SCALE_W-1:0] scale,
  output logic               en,
  output logic [DATA_W-1:0]  cmp
);
  localparam int HI_W = CNT_W - DATA_W;

  logic sel_cfg, sel_lo, sel_hi, sel_cmp;
  assign sel_cfg = (bus_addr == ADDR_W'(OFF_CFG));
  assign sel_lo  = (bus_addr == ADDR_W'(OFF_LO));
  assign sel_hi  = (bus_addr == ADDR_W'(OFF_HI));
  assign sel_cmp = (bus_addr == ADDR_W'(OFF_CMP));

  assign ld_lo = bus_wr & sel_lo;
  assign ld_hi = bus_wr & sel_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale <= '0;
      en    <= 1'b0;
      cmp   <= '1;
    end else if (bus_wr) begin
      if (sel_cfg) begin
        scale <= bus_wdata[SCALE_W-1:0];
        en    <= bus_wdata[CFG_EN_BIT];
      end
      if (sel_cmp) cmp <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_cfg) begin
      bus_rdata[SCALE_W-1:0]  = scale;
      bus_rdata[CFG_EN_BIT]   = en;
      bus_rdata[CFG_PEND_BIT] = pend;
    end else if (sel_lo) begin
      bus_rdata = cnt[DATA_W-1:0];
    end else if (sel_hi) begin
      bus_rdata[HI_W-1:0] = cnt[CNT_W-1:DATA_W];
    end else if (sel_cmp) begin
      bus_rdata = cmp;
    end
  end
endmodule

// File: rtl/rtc48_timer.sv
`timescale 1ns/1ps
module rtc48_timer #(
  parameter int CNT_W   = 48,
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [CNT_W-1:0]   cnt_w;
  logic [DATA_W-1:0]  window_w, cmp_w;
  logic [SCALE_W-1:0] scale_w;
  logic               en_w, pend_w, ld_lo_w, ld_hi_w;

  rtc48_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .SCALE_W(SCALE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt(cnt_w), .pend(pend_w), .bus_rdata(bus_rdata),
    .ld_lo(ld_lo_w), .ld_hi(ld_hi_w), .scale(scale_w), .en(en_w), .cmp(cmp_w)
  );

  rtc48_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(tick_i & en_w), .ld_lo(ld_lo_w),
    .ld_hi(ld_hi_w), .wdata(bus_wdata), .cnt(cnt_w)
  );

  rtc48_scaler #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_scl (
    .cnt(cnt_w), .scale(scale_w), .window(window_w)
  );

  rtc48_cmp #(.DATA_W(DATA_W)) u_cmp (
    .window(window_w), .cmp(cmp_w), .pend(pend_w)
  );

  assign irq_o = pend_w;
endmodule

// File: rtl/rtc48_timer_chk.sv
`timescale 1ns/1ps
module rtc48_timer_chk
  import rtc48_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt,
  input logic              en
);
  localparam int HI_W = CNT_W - DATA_W;

  logic wr_lo, wr_hi;
  assign wr_lo = bus_wr && (bus_addr == ADDR_W'(OFF_LO));
  assign wr_hi = bus_wr && (bus_addr == ADDR_W'(OFF_HI));

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !tick_i) |=> $stable(cnt)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en && !wr_lo && !wr_hi) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R6

  AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt[DATA_W-1:0] == $past(bus_wdata))); // R5

  AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt[CNT_W-1:DATA_W] == $past(bus_wdata[HI_W-1:0]))); // R4

  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_HI)) |-> (bus_rdata[DATA_W-1:HI_W] == '0)); // R4

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(tick_i || bus_wr)); // R8
endmodule

bind rtc48_timer rtc48_timer_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .cnt(cnt_w), .en(en_w)
);

// File: tb/rtc48_timer_bench.sv
`timescale 1ns/1ps
module rtc48_timer_bench;
  localparam logic [7:0] A_CFG = 8'h40, A_LO = 8'h48, A_HI = 8'h4C,
                         A_CMP = 8'h60, A_NONE = 8'h44;

  logic        clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  rtc48_timer u_rtc48_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [47:0] m_cnt;
  logic [3:0]  m_scale;
  logic        m_en;
  logic [31:0] m_cmp;

  function automatic logic [31:0] f_win(logic [47:0] c, logic [3:0] s);
    logic [47:0] t;
    t = c >> s;
    return t[31:0];
  endfunction

  function automatic logic f_pend(logic [47:0] c, logic [3:0] s, logic [31:0] k);
    return f_win(c, s) >= k;
  endfunction

  function automatic logic [31:0] f_cfg(logic [47:0] c, logic [3:0] s, logic e, logic [31:0] k);
    return {3'b0, f_pend(c, s, k), 15'b0, e, 8'b0, s};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic check_all();
    logic [31:0] v;
    rd(A_LO, v);  chk("R3 count low", v, m_cnt[31:0]);
    rd(A_HI, v);  chk("R4 count high", v, {16'h0, m_cnt[47:32]});
    rd(A_CFG, v); chk("R8 config", v, f_cfg(m_cnt, m_scale, m_en, m_cmp));
    rd(A_CMP, v); chk("R2 compare", v, m_cmp);
    chk("R8 irq", {31'b0, irq_o}, {31'b0, f_pend(m_cnt, m_scale, m_cmp)});
  endtask

  task automatic step(logic w, logic [7:0] a, logic [31:0] d, logic t);
    logic inc;
    @(negedge clk);
    check_all();
    bus_wr = w; bus_addr = a; bus_wdata = d; tick_i = t;
    @(posedge clk);
    inc = t && m_en && !(w && (a == A_LO || a == A_HI));
    if (w) begin
      case (a)
        A_LO:  m_cnt[31:0]  = d;
        A_HI:  m_cnt[47:32] = d[15:0];
        A_CFG: begin m_scale = d[3:0]; m_en = d[12]; end
        A_CMP: m_cmp = d;
        default: ;
      endcase
    end
    if (inc) m_cnt = m_cnt + 1'b1;
    #1;
    bus_wr = 1'b0; tick_i = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'h1F2E3D4C);
    m_cnt = '0; m_scale = '0; m_en = 1'b0; m_cmp = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_LO, v);  chk("R1 low after reset", v, 32'h0);
    rd(A_HI, v);  chk("R1 high after reset", v, 32'h0);
    rd(A_CFG, v); chk("R1 config after reset", v, 32'h0);
    rd(A_CMP, v); chk("R1 compare after reset", v, 32'hFFFF_FFFF);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    // R3 no counting while disabled, then counting with ticks
    step(0, A_LO, 0, 1);
    step(0, A_LO, 0, 1);
    @(negedge clk); rd(A_LO, v); chk("R3 disabled holds", v, 32'h0);
    step(1, A_CFG, 32'h0000_1000, 0);
    step(0, A_LO, 0, 1);
    step(0, A_LO, 0, 0);
    step(0, A_LO, 0, 1);
    @(negedge clk); rd(A_LO, v); chk("R3 two ticks", v, 32'h2);

    // R5 load wins over same-cycle increment
    step(1, A_LO, 32'h0000_0055, 1);
    @(negedge clk); rd(A_LO, v); chk("R5 load over tick", v, 32'h55);

    // R4 high halfword load, upper bits zero
    step(1, A_HI, 32'hABCD_1234, 0);
    @(negedge clk); rd(A_HI, v); chk("R4 high load", v, 32'h0000_1234);

    // R6 wraparound
    step(1, A_HI, 32'h0000_FFFF, 0);
    step(1, A_LO, 32'hFFFF_FFFF, 0);
    step(0, A_LO, 0, 1);
    @(negedge clk);
    rd(A_LO, v); chk("R6 wrap low", v, 32'h0);
    rd(A_HI, v); chk("R6 wrap high", v, 32'h0);

    // R7 scaled window and R8 compare set/clear
    step(1, A_CFG, 32'h0000_0004, 0);
    step(1, A_HI, 32'h0000_1234, 0);
    step(1, A_LO, 32'h5678_9ABC, 0);
    step(1, A_CMP, 32'h4567_89AB, 0);
    @(negedge clk); rd(A_CFG, v); chk("R7 window equals compare", v, 32'h1000_0004);
    step(1, A_CMP, 32'h4567_89AC, 0);
    @(negedge clk); rd(A_CFG, v); chk("R8 compare raised clears", v, 32'h0000_0004);
    chk("R8 irq cleared", {31'b0, irq_o}, 32'h0);

    // R9 read-only pending bit and reserved bits
    step(1, A_CFG, 32'hFFFF_FFFF, 0);
    @(negedge clk); rd(A_CFG, v); chk("R9 config readback", v, 32'h0000_100F);

    // R2 unmapped offset
    step(1, A_NONE, 32'hDEAD_BEEF, 0);
    @(negedge clk); rd(A_NONE, v); chk("R2 unmapped reads zero", v, 32'h0);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        w, t;
      int          pick;
      pick = int'($urandom_range(4, 0));
      case (pick)
        0: a = A_CFG; 1: a = A_LO; 2: a = A_HI; 3: a = A_CMP; default: a = A_NONE;
      endcase
      w = ($urandom_range(7, 0) == 0);
      t = ($urandom_range(1, 0) == 1);
      d = $urandom;
      if (a == A_CFG && $urandom_range(3, 0) != 0) d[12] = 1'b1;
      if (a == A_HI && $urandom_range(1, 0) == 1) d[15:0] = 16'hFFFF;
      if (a == A_LO && $urandom_range(2, 0) == 0) d = 32'hFFFF_FFF0 | (d & 32'hF);
      if (a == A_CMP && $urandom_range(1, 0) == 1) d = d & 32'h0000_03FF;
      step(w, a, d, t);
    end
    @(negedge clk);
    check_all();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule